// File: doc/BRIEF.md
# Voltage-Shift Positive Feedback Controller

This block turns a per-half-cycle voltage measurement into a deliberately destabilizing current-magnitude command for a grid-tied inverter. On each half cycle it takes a measured line voltage and the 8-bit magnitude request from the maximum-power tracker. It maps the voltage onto a fine code covering 90 V to 154 V. It keeps a slow first-order average of that code and forms an error: the present code minus the average.

The applied command is the tracker request plus two error terms. One has a fixed gain. The other is scaled by the present power level. While the grid holds the voltage, the error stays small and the command stays close to the request. When an isolated section loses the grid's voltage support, any drift in voltage moves the command in the same direction. That pushes the voltage further until a separate trip function acts.

Each result leaves on `cmd_out` with a one-cycle `cmd_valid` pulse, one clock after the sample is accepted.

Top module: `vshift_fb`

## Requirements
- R1: While reset is asserted and directly after it, `cmd_out` is 0 and `cmd_valid` is 0.
- R2: `cmd_valid` is high for exactly the one cycle after each cycle with `sample_valid` high. `cmd_out` changes only in that cycle.
- R3: `volt_in` is unsigned with an LSB of 1/8 V. The scaled code is floor((volt_in − 720) / 2), clamped to 0..256, so 4 codes equal 1 V.
- R4: The first sample after reset loads the filter with that sample's code exactly. That sample's error is therefore 0.
- R5: Every later sample updates the filter state F (code with 8 fractional bits) as F' = F − floor(F/256) + code.
- R6: The error is code − floor((F' + 128)/256), clamped to −127..+127.
- R7: The command is floor((P·2^20 + E·87381 + E·P·2988 + 2^19) / 2^20). P is `track_cmd` and E is the error. This rounds P + E/12 + E·(P/200)·0.57.
- R8: The command saturates to 255 above and to 0 below.
- R9: A sample whose error is 0 produces a command equal to `track_cmd`.
- R10: Cycles with `sample_valid` low change neither the filter state nor `cmd_out`, whatever `volt_in` and `track_cmd` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new half-cycle sample |
| volt_in | input | 12 | Measured line voltage, 1/8 V per LSB |
| track_cmd | input | 8 | Magnitude request from the power tracker (200 = full output) |
| cmd_out | output | 8 | Applied current-magnitude command |
| cmd_valid | output | 1 | Pulses for one cycle when `cmd_out` is updated |

## Verification
The assertions take `sample_valid` to be a strobe that may be high in consecutive cycles. They take `volt_in` and `track_cmd` to be meaningful only while the strobe is high. The bench therefore drives the strobe for single cycles and leaves idle gaps between samples. It loads garbage on the data inputs during those gaps, to show that the inputs are ignored. The stimulus starts every filter sequence from a fresh reset, so the first-sample priming rule is always in force when an assertion relies on it. The stimulus also includes voltages outside 90–154 V and opposite-direction steps large enough to exercise both the error clamp and the output saturation.

// File: rtl/vshift_fb.sv
module vshift_fb #(
  parameter int VIN_W     = 12,
  parameter int VIN_FRAC  = 3,
  parameter int FILT_SH   = 8,
  parameter int OUT_SH    = 20,
  parameter int CMD_W     = 8,
  parameter int ERR_LIM   = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_valid,
  input  logic [VIN_W-1:0] volt_in,
  input  logic [CMD_W-1:0] track_cmd,
  output logic [CMD_W-1:0] cmd_out,
  output logic             cmd_valid
);

  localparam int OFF   = 90 << VIN_FRAC;
  localparam int SH    = VIN_FRAC - 2;
  localparam int CMAX  = 256;
  localparam int CW    = 9;
  localparam int FW    = CW + FILT_SH;
  localparam int HALF  = 1 << (FILT_SH - 1);
  localparam int K1    = ((1 << OUT_SH) + 6) / 12;
  localparam int K2    = (57 * (1 << OUT_SH) + 10000) / 20000;
  localparam int OMAX  = (1 << CMD_W) - 1;
  localparam int FMAX  = CMAX << FILT_SH;

  logic [FW-1:0]    filt, fnext;
  logic             primed;
  logic [CW-1:0]    code;
  logic [CMD_W-1:0] cmd_d;
  logic signed [CMD_W:0] err;
  int d, e, acc;

  always_comb begin
    d = (int'(volt_in) - OFF) >>> SH;
    if (d < 0) d = 0;
    else if (d > CMAX) d = CMAX;
    code = d[CW-1:0];

    if (primed) fnext = filt - (filt >> FILT_SH) + FW'(code);
    else        fnext = {code, {FILT_SH{1'b0}}};

    e = int'(code) - ((int'(fnext) + HALF) >>> FILT_SH);
    if (e > ERR_LIM) e = ERR_LIM;
    else if (e < -ERR_LIM) e = -ERR_LIM;
    err = e[CMD_W:0];

    acc = (int'(track_cmd) <<< OUT_SH) + e * K1 + e * int'(track_cmd) * K2
          + (1 <<< (OUT_SH - 1));
    acc = acc >>> OUT_SH;
    if (acc < 0) acc = 0;
    else if (acc > OMAX) acc = OMAX;
    cmd_d = acc[CMD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt      <= '0;
      primed    <= 1'b0;
      cmd_out   <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= sample_valid;
      if (sample_valid) begin
        filt    <= fnext;
        primed  <= 1'b1;
        cmd_out <= cmd_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> cmd_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !cmd_valid);

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(cmd_out) && $stable(filt)));

  // R4
  prime_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !primed) |=> (filt == {$past(code), {FILT_SH{1'b0}}}));

  // R9
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && err == 0) |=> (cmd_out == $past(track_cmd)));

  // R5
  filt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(filt) <= FMAX);

endmodule

// File: tb/vshift_fb_test.sv
module vshift_fb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [11:0] volt_in = '0;
  logic [7:0]  track_cmd = '0;
  logic [7:0]  cmd_out;
  logic        cmd_valid;

  int checks = 0;
  int errors = 0;
  int mf = 0;
  bit mprimed = 0;
  bit done = 0;

  vshift_fb uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .volt_in(volt_in), .track_cmd(track_cmd),
    .cmd_out(cmd_out), .cmd_valid(cmd_valid)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int v, input int p);
    int c, e, a;
    c = (v - 720) >>> 1;
    if (c < 0) c = 0;
    if (c > 256) c = 256;
    if (!mprimed) mf = c * 256;
    else mf = mf - (mf / 256) + c;
    mprimed = 1;
    e = c - ((mf + 128) >>> 8);
    if (e > 127) e = 127;
    if (e < -127) e = -127;
    a = (p * 1048576 + e * 87381 + e * p * 2988 + 524288) >>> 20;
    if (a < 0) a = 0;
    if (a > 255) a = 255;
    return a;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mprimed = 0;
    mf = 0;
  endtask

  task automatic send(input int v, input int p, input string req, output int got);
    int exp;
    exp = model(v, p);
    @(negedge clk);
    volt_in = v[11:0];
    track_cmd = p[7:0];
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    chk("R2 valid pulse", int'(cmd_valid), 1);
    chk(req, int'(cmd_out), exp);
    got = int'(cmd_out);
    @(negedge clk);
    chk("R2 valid drop", int'(cmd_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cmd_out in reset", int'(cmd_out), 0);
    chk("R1 cmd_valid in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd_out after reset", int'(cmd_out), 0);
  endtask

  task automatic t_prime_steady();
    int g;
    do_reset();
    send(1000, 100, "R4 first sample gives P", g);
    chk("R9 zero error equals P", g, 100);
    for (int i = 0; i < 4; i++) begin
      send(1000, 150, "R5 steady input", g);
      chk("R9 steady zero error", g, 150);
    end
  endtask

  task automatic t_steps();
    int g;
    do_reset();
    send(1000, 100, "R4 prime", g);
    send(1040, 100, "R7 step up", g);
    chk("R7 step up value", g, 107);
    send(960, 100, "R7 step down", g);
    chk("R7 step down below P", int'(g < 100), 1);
    for (int i = 0; i < 5; i++) send(1010 + 7 * i, 180, "R6 ramp", g);
  endtask

  task automatic t_scale();
    int g;
    do_reset();
    send(100, 60, "R3 below range clamps", g);
    send(100, 60, "R3 below range steady", g);
    chk("R3 low clamp zero error", g, 60);
    do_reset();
    send(4000, 90, "R3 above range clamps", g);
    send(3000, 90, "R3 still clamped 256", g);
    chk("R3 high clamp zero error", g, 90);
  endtask

  task automatic t_sat();
    int g;
    do_reset();
    send(700, 255, "R4 prime at 0", g);
    send(4000, 255, "R6 clamp +127 R8 sat high", g);
    chk("R8 saturates 255", g, 255);
    do_reset();
    send(4000, 0, "R4 prime at 256", g);
    send(0, 0, "R6 clamp -127 R8 sat low", g);
    chk("R8 saturates 0", g, 0);
    do_reset();
    send(700, 0, "R4 prime", g);
    send(4000, 0, "R6 error clamp P=0", g);
    chk("R6 clamped error gives 11", g, 11);
  endtask

  task automatic t_hold();
    int g, held;
    do_reset();
    send(1000, 120, "R4 prime", g);
    send(1030, 120, "R7 step", g);
    held = g;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      volt_in = 12'(3000 + 100 * i);
      track_cmd = 8'(17 * i);
      @(negedge clk);
      chk("R10 output held", int'(cmd_out), held);
      chk("R10 no valid", int'(cmd_valid), 0);
    end
    send(1030, 120, "R10 filter untouched", g);
  endtask

  initial begin
    t_reset();
    t_prime_steady();
    t_steps();
    t_scale();
    t_sat();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule